// File: doc/BRIEF.md
# IR carrier-modulated pulse transmitter

This block produces an infrared remote-control waveform one section at a time. Software picks a level and a section length. While the level is high, the block passes a carrier waveform to the output pin. While the level is low, it holds the pin low. The length is an 8-bit count, set to the section duration multiplied by the rate of the length-counter tick. The count goes down by one on each tick.

When the count reaches zero, the counter stops there and a sticky cause flag is raised. The flag drives the interrupt line when the interrupt is enabled. Software then writes the next level and length. After the last section has ended, software clears the enable. The block works only when it is enabled and the mode input selects transmit. All writes are single-cycle strobes in the system clock domain. No data path here streams, so no port carries back-pressure.

Top module: `ir_pulse_tx`

## Requirements
- R1: After reset, `tx_o`, `irq_o` and `cause_o` are 0 and `count_o` is 0.
- R2: When active (`en_i`=1 and `mode_i`=0) with a stored level of 1, `tx_o` shows at each clock edge the `carrier_i` value sampled at that edge. The output has one register of latency.
- R3: A stored level of 0 keeps `tx_o` at 0 whatever `carrier_i` does.
- R4: An active length write loads `len_i` into `count_o` at the next edge. Each `len_tick_i` cycle then lowers it by one, and cycles without a tick leave it unchanged.
- R5: When a tick takes the count from 1 to 0, `cause_o` is 1 after that same edge. The count then stays at 0 under further ticks, and no new cause is raised.
- R6: `irq_o` is `cause_o` AND `irq_en_i`. The cause stays set while `irq_en_i` is 0.
- R7: `cause_clr_i`=1 clears the cause at the next edge. If an underflow happens in the same cycle, the cause is set instead.
- R8: A length write during a count reloads the count at once, and a write takes priority over a tick in the same cycle.
- R9: When not active (`en_i`=0 or `mode_i`=1), the block does the following:
  - `tx_o` goes to 0 and stays there.
  - The count and the stored level are cleared.
  - Level and length writes are ignored.
  - The cause flag keeps its value.
- R10: An active write of length 0 sets the cause at the write edge and leaves the count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Block enable |
| mode_i | input | 1 | 0 = transmit, 1 = receive (inactive here) |
| carrier_i | input | 1 | Carrier waveform, synchronous to clk |
| len_tick_i | input | 1 | Single-cycle length-counter tick |
| lvl_wr_i | input | 1 | Level write strobe |
| lvl_i | input | 1 | Level to store |
| len_wr_i | input | 1 | Length write strobe |
| len_i | input | LEN_W | Section length |
| irq_en_i | input | 1 | Interrupt enable |
| cause_clr_i | input | 1 | Write-1-to-clear for the cause flag |
| tx_o | output | 1 | Modulated output pin |
| irq_o | output | 1 | Interrupt request |
| cause_o | output | 1 | Sticky underflow cause |
| count_o | output | LEN_W | Current length count |

## Verification
The hardest situations to reach are the ones where two events land in the same cycle. One is a reload or a clear arriving on the exact cycle of a count's last tick. The other is an underflow from a zero-length write. To reach them, the bench first brings the counter to exactly 1 with a known number of ticks. It then applies the colliding strobe together with the final tick. Every length from 0 to 255 is swept with back-to-back ticks, and the edge where the cause rises is checked against the length.

// File: rtl/ir_tx_pkg.sv
package ir_tx_pkg;
  localparam int unsigned LEN_W_DEF = 8;
  typedef enum logic {MODE_TX = 1'b0, MODE_RX = 1'b1} ir_mode_e;
endpackage

// File: rtl/ir_len_counter.sv
module ir_len_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o,
  output logic         uf_o
);
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W-1:0] cnt_q;

  // underflow event: zero-length load, or last tick of a running count
  always_comb begin
    if (clr_i)     uf_o = 1'b0;
    else if (ld_i) uf_o = (ld_val_i == ZERO);
    else           uf_o = tick_i && (cnt_q == ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt_q <= ZERO;
    else if (clr_i)                    cnt_q <= ZERO;
    else if (ld_i)                     cnt_q <= ld_val_i;
    else if (tick_i && cnt_q != ZERO)  cnt_q <= cnt_q - ONE;
  end

  assign cnt_o = cnt_q;

  p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_i && !clr_i) |=> cnt_q == $past(ld_val_i));
  p_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !ld_i && tick_i && cnt_q != ZERO) |=> cnt_q == $past(cnt_q) - ONE);
  p_still_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !ld_i && !tick_i) |=> $stable(cnt_q));
  p_hold_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_i && cnt_q == ZERO) |=> cnt_q == ZERO);
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> cnt_q == ZERO);
endmodule

// File: rtl/ir_cause_flag.sv
module ir_cause_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q);
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_q);
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(flag_q));
endmodule

// File: rtl/ir_carrier_gate.sv
module ir_carrier_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic act_i,
  input  logic lvl_wr_i,
  input  logic lvl_i,
  input  logic carrier_i,
  output logic tx_o
);
  logic level_q;
  logic tx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        level_q <= 1'b0;
    else if (!act_i)   level_q <= 1'b0;
    else if (lvl_wr_i) level_q <= lvl_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_q <= 1'b0;
    else        tx_q <= act_i & level_q & carrier_i;
  end

  assign tx_o = tx_q;

  p_low_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !level_q |=> !tx_q);
  p_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !act_i |=> !tx_q);
  p_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (act_i && level_q) |=> tx_q == $past(carrier_i));
endmodule

// File: rtl/ir_pulse_tx.sv
module ir_pulse_tx
  import ir_tx_pkg::*;
#(
  parameter int unsigned LEN_W = LEN_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             mode_i,
  input  logic             carrier_i,
  input  logic             len_tick_i,
  input  logic             lvl_wr_i,
  input  logic             lvl_i,
  input  logic             len_wr_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             irq_en_i,
  input  logic             cause_clr_i,
  output logic             tx_o,
  output logic             irq_o,
  output logic             cause_o,
  output logic [LEN_W-1:0] count_o
);
  logic active;
  logic uf;

  assign active = en_i && (ir_mode_e'(mode_i) == MODE_TX);

  ir_len_counter #(.W(LEN_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (!active),
    .ld_i     (len_wr_i && active),
    .ld_val_i (len_i),
    .tick_i   (len_tick_i),
    .cnt_o    (count_o),
    .uf_o     (uf)
  );

  ir_cause_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (uf),
    .clr_i  (cause_clr_i),
    .flag_o (cause_o)
  );

  ir_carrier_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .act_i     (active),
    .lvl_wr_i  (lvl_wr_i),
    .lvl_i     (lvl_i),
    .carrier_i (carrier_i),
    .tx_o      (tx_o)
  );

  assign irq_o = cause_o & irq_en_i;

  p_zero_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (active && len_wr_i && len_i == '0) |=> (cause_o && count_o == '0));
  p_keep_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !cause_clr_i) |=> $stable(cause_o));
endmodule

// File: tb/ir_pulse_tx_test.sv
module ir_pulse_tx_test;
  localparam int CLK_NS = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_i = 1'b0, mode_i = 1'b0, carrier_i = 1'b0, len_tick_i = 1'b0;
  logic lvl_wr_i = 1'b0, lvl_i = 1'b0, len_wr_i = 1'b0;
  logic [W-1:0] len_i = '0;
  logic irq_en_i = 1'b0, cause_clr_i = 1'b0;
  logic tx_o, irq_o, cause_o;
  logic [W-1:0] count_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  ir_pulse_tx #(.LEN_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .mode_i(mode_i),
    .carrier_i(carrier_i), .len_tick_i(len_tick_i), .lvl_wr_i(lvl_wr_i),
    .lvl_i(lvl_i), .len_wr_i(len_wr_i), .len_i(len_i), .irq_en_i(irq_en_i),
    .cause_clr_i(cause_clr_i), .tx_o(tx_o), .irq_o(irq_o), .cause_o(cause_o),
    .count_o(count_o)
  );

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_len(input int v);
    len_wr_i = 1'b1; len_i = W'(v);
    cyc();
    len_wr_i = 1'b0;
  endtask

  task automatic wr_lvl(input bit v);
    lvl_wr_i = 1'b1; lvl_i = v;
    cyc();
    lvl_wr_i = 1'b0;
  endtask

  task automatic clr_cause();
    cause_clr_i = 1'b1;
    cyc();
    cause_clr_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      len_tick_i = 1'b1;
      cyc();
    end
    len_tick_i = 1'b0;
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 tx", tx_o, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 cause", cause_o, 0);
    chk("R1 count", count_o, 0);
    rst_n = 1'b1;
    en_i = 1'b1;
    cyc();

    // R2: carrier follows with level 1, one register of latency
    wr_lvl(1'b1);
    for (int i = 0; i < 32; i++) begin
      carrier_i = ((i * 5 + 3) % 7) > 2;
      cyc();
      chk("R2 carrier pass", tx_o, int'(carrier_i));
    end
    // R3: level 0 blocks the carrier
    wr_lvl(1'b0);
    for (int i = 0; i < 16; i++) begin
      carrier_i = i[0];
      cyc();
      chk("R3 level low", tx_o, 0);
    end

    // R4/R5/R10: sweep every length with back-to-back ticks
    for (int len = 0; len < 256; len++) begin
      clr_cause();
      wr_len(len);
      chk("R4 load", count_o, len);
      if (len == 0) chk("R10 zero len cause", cause_o, 1);
      for (int t = 1; t <= len; t++) begin
        len_tick_i = 1'b1;
        cyc();
        chk("R4 decrement", count_o, len - t);
        chk("R5 cause edge", cause_o, (t == len) ? 1 : 0);
      end
      len_tick_i = 1'b0;
      clr_cause();
      ticks(2);
      chk("R5 hold zero", count_o, 0);
      chk("R5 no new cause", cause_o, 0);
    end

    // R4: no tick, no change
    wr_len(9);
    repeat (5) cyc();
    chk("R4 idle hold", count_o, 9);
    ticks(2);
    chk("R4 sparse tick", count_o, 7);

    // R8: reload while running, write beats tick
    len_tick_i = 1'b1;
    wr_len(5);
    len_tick_i = 1'b0;
    chk("R8 reload priority", count_o, 5);
    ticks(4);
    chk("R8 at one", count_o, 1);
    len_tick_i = 1'b1;
    wr_len(20);
    len_tick_i = 1'b0;
    chk("R8 reload on last tick", count_o, 20);
    chk("R8 no cause", cause_o, 0);

    // R7: clear and underflow together -> set wins
    wr_len(1);
    len_tick_i = 1'b1; cause_clr_i = 1'b1;
    cyc();
    len_tick_i = 1'b0; cause_clr_i = 1'b0;
    chk("R7 set wins", cause_o, 1);
    clr_cause();
    chk("R7 clear", cause_o, 0);

    // R6: interrupt gating with sticky cause
    wr_len(0);
    chk("R6 cause irq off", cause_o, 1);
    chk("R6 irq masked", irq_o, 0);
    irq_en_i = 1'b1; #1;
    chk("R6 irq enabled", irq_o, 1);
    irq_en_i = 1'b0; #1;
    chk("R6 irq masked again", irq_o, 0);

    // R9: disable keeps cause, clears state, ignores writes
    wr_lvl(1'b1); wr_len(30);
    carrier_i = 1'b1;
    en_i = 1'b0;
    cyc();
    cyc();
    chk("R9 tx off", tx_o, 0);
    chk("R9 count cleared", count_o, 0);
    chk("R9 cause kept", cause_o, 1);
    wr_len(12);
    chk("R9 len ignored", count_o, 0);
    wr_lvl(1'b1);
    en_i = 1'b1;
    cyc();
    cyc();
    chk("R9 level cleared", tx_o, 0);
    // receive mode also inactive
    wr_lvl(1'b1);
    cyc();
    chk("R9 tx on before mode", tx_o, 1);
    mode_i = 1'b1;
    wr_len(40);
    chk("R9 rx mode count", count_o, 0);
    chk("R9 rx mode tx", tx_o, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule